// File: doc/BRIEF.md
# Status Register and Write Permission Unit

This block keeps the eight-bit status register of a serial nonvolatile memory and decides, each cycle, whether a byte write to the memory array and a rewrite of the status register may proceed. The command decoder in front of it delivers one-cycle strobes: set-enable, clear-enable, start and completion of a status rewrite (with its data byte), and completion of an array write command. It also supplies the level of the write-protect pin and the 13-bit address of the byte being written. The block returns the status byte for read-out and two permit levels that the array and status write paths obey.

The register holds a write-enable latch, a two-bit region-lock field that covers the top quarter, the top half or all of the array, a status-lock bit that, together with a low write-protect pin, freezes the register, and three spare bits that can be written and read back. The upper six bits model nonvolatile storage: an ordinary reset leaves them alone, and only an explicit initialisation strobe clears them. The write-protect pin is captured when a status rewrite starts, and that captured level governs the whole command.

Top module: `nvm_status_guard`

## Requirements
- R1: While `rst_n` is low and after it is released, the enable latch (status bit 1) reads 0 and both permits are 0 until an enable strobe arrives; status bit 0 always reads 0.
- R2: `cmd_wren` sets the enable latch so that it reads 1 from the next cycle; `cmd_wrdi` clears it from the next cycle.
- R3: A completed status rewrite (`cmd_wrsr_done`) or a completed array write command (`cmd_write_done`) clears the enable latch from the next cycle, whether or not the write was permitted; any clearing strobe wins over `cmd_wren` in the same cycle.
- R4: A permitted status rewrite loads data bits 7..2 into status bits 7..2 from the next cycle; data bits 1 and 0 are ignored.
- R5: With the enable latch at 0, `array_wr_ok` and `status_wr_ok` are both 0 and a status rewrite leaves the register unchanged.
- R6: With region-lock field status[3:2] = 00 nothing is locked, 01 locks addresses 0x1800 to 0x1FFF, 10 locks 0x1000 to 0x1FFF and 11 locks all addresses; `array_wr_ok` is 1 only when the enable latch is 1 and the address is not locked.
- R7: `status_wr_ok` is 1 when the enable latch is 1 and either status-lock bit 7 is 0 or the effective write-protect level is 1; a rewrite completed while it is 0 leaves bits 7..2 unchanged.
- R8: The write-protect level is captured on `cmd_wrsr_start`; between start and completion the captured level is used and pin changes have no effect on `status_wr_ok` or on the outcome.
- R9: Status bits 7..2 keep their values through a low pulse on `rst_n`; `nv_init` clears them to 0 on the next clock edge.
- R10: `array_wr_ok` does not depend on status bit 7 or on the write-protect pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-up reset of the volatile state |
| nv_init | input | 1 | Synchronous clear of the nonvolatile bits 7..2 |
| cmd_wren | input | 1 | Set-enable strobe |
| cmd_wrdi | input | 1 | Clear-enable strobe |
| cmd_wrsr_start | input | 1 | Status rewrite command begins; captures the write-protect pin |
| cmd_wrsr_done | input | 1 | Status rewrite command completes; applies `sr_wdata` if permitted |
| sr_wdata | input | 8 | Data byte of the status rewrite |
| cmd_write_done | input | 1 | Array write command completes |
| wp_pin | input | 1 | Write-protect pin level, 0 = protect |
| tgt_addr | input | 13 | Address of the array byte about to be written |
| status_q | output | 8 | Status byte for read-out |
| array_wr_ok | output | 1 | Array byte write at `tgt_addr` is permitted |
| status_wr_ok | output | 1 | Status rewrite is permitted |

## Verification
The region-lock decoding is tried with a table of addresses that sit on both sides of every lock boundary (0x0FFF/0x1000, 0x17FF/0x1800) and at the array ends, under each of the four lock settings, which separates a wrong boundary or a swapped field from a correct decode. The status permit is driven through all combinations of enable latch, status-lock bit and pin level, and with the pin toggled in mid-command in both directions, which tells a captured level from a live one. Rewrites with data bits 1 and 0 set, clears colliding with sets, and a reset without initialisation show whether the latch and the retained bits are kept apart.

// File: rtl/nvsg_pkg.sv
package nvsg_pkg;

  typedef enum logic [1:0] {
    LOCK_NONE    = 2'b00,
    LOCK_QUARTER = 2'b01,
    LOCK_HALF    = 2'b10,
    LOCK_ALL     = 2'b11
  } lock_sel_e;

  // Region lock test on the two top address bits.
  function automatic logic region_locked(input logic [1:0] sel, input logic [1:0] top2);
    case (lock_sel_e'(sel))
      LOCK_NONE:    return 1'b0;
      LOCK_QUARTER: return (top2 == 2'b11);
      LOCK_HALF:    return top2[1];
      default:      return 1'b1;
    endcase
  endfunction

  // Status rewrite permission.
  function automatic logic sr_permit(input logic en, input logic lock_bit, input logic wp_lvl);
    return en & (~lock_bit | wp_lvl);
  endfunction

endpackage

// File: rtl/nvsg_enable_latch.sv
module nvsg_enable_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic en_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= 1'b0;
    else if (clr_req) en_q <= 1'b0;
    else if (set_req) en_q <= 1'b1;
  end

  a_r2_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req && !clr_req) |=> en_q);
  a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> !en_q);
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_n) && !$past(set_req)) |-> !en_q);

endmodule

// File: rtl/nvsg_nv_bits.sv
module nvsg_nv_bits #(
  parameter int SRW = 8,
  localparam int NVW = SRW - 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           nv_init,
  input  logic           wr_en,
  input  logic [SRW-1:0] wdata,
  output logic [NVW-1:0] nv_q
);

  // No reset: contents survive rst_n, only nv_init clears them.
  always_ff @(posedge clk) begin
    if (nv_init)    nv_q <= '0;
    else if (wr_en) nv_q <= wdata[SRW-1:2];
  end

  a_r9_retained: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !nv_init) |=> $stable(nv_q));
  a_r4_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !nv_init) |=> (nv_q == $past(wdata[SRW-1:2])));

endmodule

// File: rtl/nvsg_wp_ctl.sv
module nvsg_wp_ctl
  import nvsg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wrsr_start,
  input  logic wrsr_done,
  input  logic wp_pin,
  input  logic en_q,
  input  logic en_steady,
  input  logic lock_bit,
  output logic status_ok
);

  logic in_cmd;
  logic wp_held;
  logic wp_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_cmd  <= 1'b0;
      wp_held <= 1'b1;
    end else begin
      if (wrsr_start) begin
        in_cmd  <= 1'b1;
        wp_held <= wp_pin;
      end else if (wrsr_done) begin
        in_cmd  <= 1'b0;
      end
    end
  end

  assign wp_eff    = in_cmd ? wp_held : wp_pin;
  assign status_ok = sr_permit(en_q, lock_bit, wp_eff);

  a_r5_status_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !status_ok);
  a_r8_pin_ignored_in_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cmd && !wrsr_start && !wrsr_done && en_steady) |=> $stable(status_ok));

endmodule

// File: rtl/nvsg_region_lock.sv
module nvsg_region_lock
  import nvsg_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    lock_sel,
  input  logic [AW-1:0] addr,
  input  logic          en_q,
  output logic          array_ok
);

  logic locked;

  assign locked   = region_locked(lock_sel, addr[AW-1:AW-2]);
  assign array_ok = en_q & ~locked;

  a_r5_array_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !array_ok);
  a_r6_all_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_sel == 2'b11) |-> !array_ok);
  a_r6_none_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_sel == 2'b00 && en_q) |-> array_ok);

endmodule

// File: rtl/nvm_status_guard.sv
module nvm_status_guard #(
  parameter int AW  = 13,
  parameter int SRW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           nv_init,
  input  logic           cmd_wren,
  input  logic           cmd_wrdi,
  input  logic           cmd_wrsr_start,
  input  logic           cmd_wrsr_done,
  input  logic [SRW-1:0] sr_wdata,
  input  logic           cmd_write_done,
  input  logic           wp_pin,
  input  logic [AW-1:0]  tgt_addr,
  output logic [SRW-1:0] status_q,
  output logic           array_wr_ok,
  output logic           status_wr_ok
);

  localparam int NVW     = SRW - 2;
  localparam int LOCK_HI = NVW - 1;

  logic           en_q;
  logic           en_clr;
  logic           en_steady;
  logic           sr_commit;
  logic [NVW-1:0] nv_q;
  logic           lock_bit;
  logic [1:0]     lock_sel;

  assign en_clr    = cmd_wrdi | cmd_wrsr_done | cmd_write_done;
  assign en_steady = ~(cmd_wren | en_clr);
  assign sr_commit = cmd_wrsr_done & status_wr_ok;
  assign lock_bit  = nv_q[LOCK_HI];
  assign lock_sel  = nv_q[1:0];

  nvsg_enable_latch u_en (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (cmd_wren),
    .clr_req (en_clr),
    .en_q    (en_q)
  );

  nvsg_nv_bits #(.SRW(SRW)) u_nv (
    .clk     (clk),
    .rst_n   (rst_n),
    .nv_init (nv_init),
    .wr_en   (sr_commit),
    .wdata   (sr_wdata),
    .nv_q    (nv_q)
  );

  nvsg_wp_ctl u_wp (
    .clk        (clk),
    .rst_n      (rst_n),
    .wrsr_start (cmd_wrsr_start),
    .wrsr_done  (cmd_wrsr_done),
    .wp_pin     (wp_pin),
    .en_q       (en_q),
    .en_steady  (en_steady),
    .lock_bit   (lock_bit),
    .status_ok  (status_wr_ok)
  );

  nvsg_region_lock #(.AW(AW)) u_rl (
    .clk      (clk),
    .rst_n    (rst_n),
    .lock_sel (lock_sel),
    .addr     (tgt_addr),
    .en_q     (en_q),
    .array_ok (array_wr_ok)
  );

  assign status_q = {nv_q, en_q, 1'b0};

  a_r3_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wrsr_done || cmd_write_done) |=> !status_q[1]);
  a_r7_blocked_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wrsr_done && !status_wr_ok && !nv_init) |=> $stable(status_q[SRW-1:2]));

endmodule

// File: tb/nvm_status_guard_test.sv
module nvm_status_guard_test;

  logic        clk = 1'b0;
  logic        rst_n, nv_init, cmd_wren, cmd_wrdi, cmd_wrsr_start, cmd_wrsr_done;
  logic        cmd_write_done, wp_pin;
  logic [7:0]  sr_wdata;
  logic [12:0] tgt_addr;
  logic [7:0]  status_q;
  logic        array_wr_ok, status_wr_ok;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  nvm_status_guard uut (
    .clk(clk), .rst_n(rst_n), .nv_init(nv_init), .cmd_wren(cmd_wren),
    .cmd_wrdi(cmd_wrdi), .cmd_wrsr_start(cmd_wrsr_start), .cmd_wrsr_done(cmd_wrsr_done),
    .sr_wdata(sr_wdata), .cmd_write_done(cmd_write_done), .wp_pin(wp_pin),
    .tgt_addr(tgt_addr), .status_q(status_q), .array_wr_ok(array_wr_ok),
    .status_wr_ok(status_wr_ok)
  );

  // {lock field, address, expected array permit with enable set}
  localparam logic [15:0] VEC [0:9] = '{
    {2'd0, 13'h1FFF, 1'b1}, {2'd0, 13'h0000, 1'b1},
    {2'd1, 13'h17FF, 1'b1}, {2'd1, 13'h1800, 1'b0},
    {2'd1, 13'h0000, 1'b1}, {2'd2, 13'h0FFF, 1'b1},
    {2'd2, 13'h1000, 1'b0}, {2'd2, 13'h1FFF, 1'b0},
    {2'd3, 13'h0000, 1'b0}, {2'd3, 13'h1FFF, 1'b0}
  };

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wren;
    cmd_wren = 1'b1; tick; cmd_wren = 1'b0;
  endtask

  // start with wp_a, pin becomes wp_b mid-command, finish with data
  task automatic wrsr(input logic [7:0] d, input logic wp_a, input logic wp_b);
    wp_pin = wp_a; cmd_wrsr_start = 1'b1; tick; cmd_wrsr_start = 1'b0;
    wp_pin = wp_b; tick;
    sr_wdata = d; cmd_wrsr_done = 1'b1; tick; cmd_wrsr_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; nv_init = 1'b1; cmd_wren = 1'b0; cmd_wrdi = 1'b0;
    cmd_wrsr_start = 1'b0; cmd_wrsr_done = 1'b0; cmd_write_done = 1'b0;
    wp_pin = 1'b1; sr_wdata = 8'h00; tgt_addr = 13'h0000;
    tick; tick; tick;
    nv_init = 1'b0; rst_n = 1'b1; tick;

    // R1 reset state
    check("R1 status", status_q, 8'h00);
    check("R1 permits", {array_wr_ok, status_wr_ok}, 2'b00);

    // R2 set and clear
    wren;
    check("R2 set", status_q, 8'h02);
    check("R2 permits", {array_wr_ok, status_wr_ok}, 2'b11);
    cmd_wrdi = 1'b1; tick; cmd_wrdi = 1'b0;
    check("R2 clear", status_q, 8'h00);

    // R5 rewrite without enable is dropped
    check("R5 permits", {array_wr_ok, status_wr_ok}, 2'b00);
    wrsr(8'hFC, 1'b1, 1'b1);
    check("R5 no change", status_q, 8'h00);

    // R6 lock table
    for (int i = 0; i < 10; i++) begin
      wren;
      wrsr({4'b0000, VEC[i][15:14], 2'b11}, 1'b1, 1'b1);
      check("R4 lock load", status_q, {4'b0000, VEC[i][15:14], 2'b00});
      tgt_addr = VEC[i][13:1];
      wren;
      check("R6 region", array_wr_ok, VEC[i][0]);
    end
    cmd_wrdi = 1'b1; tick; cmd_wrdi = 1'b0;

    // R4 data bits 1,0 ignored, R3 rewrite clears enable
    wren;
    wrsr(8'hFF, 1'b1, 1'b1);
    check("R4 R3 all ones", status_q, 8'hFC);
    wren;
    wrsr(8'h80, 1'b1, 1'b1);
    check("R4 lock bit only", status_q, 8'h80);

    // R7 lock bit + low pin blocks
    wp_pin = 1'b0; wren;
    check("R7 permit low pin", status_wr_ok, 1'b0);
    wp_pin = 1'b1; tick;
    check("R7 permit high pin", status_wr_ok, 1'b1);
    wrsr(8'h0C, 1'b0, 1'b0);
    check("R7 blocked keeps", status_q, 8'h80);

    // R8 captured high, pin drops mid-command
    wren;
    wp_pin = 1'b1; cmd_wrsr_start = 1'b1; tick; cmd_wrsr_start = 1'b0;
    wp_pin = 1'b0; tick;
    check("R8 held high", status_wr_ok, 1'b1);
    sr_wdata = 8'h84; cmd_wrsr_done = 1'b1; tick; cmd_wrsr_done = 1'b0;
    check("R8 write applied", status_q, 8'h84);

    // R8 captured low, pin rises mid-command
    wren;
    wp_pin = 1'b0; cmd_wrsr_start = 1'b1; tick; cmd_wrsr_start = 1'b0;
    wp_pin = 1'b1; tick;
    check("R8 held low", status_wr_ok, 1'b0);
    sr_wdata = 8'h80; cmd_wrsr_done = 1'b1; tick; cmd_wrsr_done = 1'b0;
    check("R8 write dropped", status_q, 8'h84);

    // R10 array permit ignores lock bit and pin (lock field 01)
    wp_pin = 1'b0; wren;
    tgt_addr = 13'h0100; tick;
    check("R10 low region", array_wr_ok, 1'b1);
    tgt_addr = 13'h1900; tick;
    check("R10 locked region", array_wr_ok, 1'b0);

    // R3 array write completion clears enable
    cmd_write_done = 1'b1; tick; cmd_write_done = 1'b0;
    check("R3 write done", status_q, 8'h84);

    // R3 clear beats set in the same cycle
    cmd_wren = 1'b1; cmd_wrdi = 1'b1; tick; cmd_wren = 1'b0; cmd_wrdi = 1'b0;
    check("R3 clear wins", status_q, 8'h84);
    cmd_wren = 1'b1; cmd_write_done = 1'b1; tick; cmd_wren = 1'b0; cmd_write_done = 1'b0;
    check("R3 done beats set", status_q[1], 1'b0);

    // R9 retained through reset, cleared by nv_init
    wren;
    rst_n = 1'b0; tick; tick; rst_n = 1'b1; tick;
    check("R9 retained", status_q, 8'h84);
    check("R1 after reset", {array_wr_ok, status_wr_ok}, 2'b00);
    nv_init = 1'b1; tick; nv_init = 1'b0;
    check("R9 init clears", status_q, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule